// File: doc/BRIEF.md
# Box-Car Audio Smoothing Filter

This block softens a signed audio sample stream by replacing each sample with the mean of the most recent 2^DEPTH samples. Used after a square-wave tone generator, it behaves like a treble cut: hard edges become short ramps, and the length of a ramp is set by DEPTH. A depth of 4 is the default. Depths of 5 and 6 give a stronger cut.

New samples arrive on a clock-enable strobe, which typically runs at a fraction of the system clock (a quarter of the core clock, for example). Samples are two's-complement values centred on zero. The result has the same width as the input. One clock after each accepted sample, the result is registered and a valid flag is raised for that one cycle.

Internally the block keeps a running sum and a circular history of the last 2^DEPTH samples. Division by 2^DEPTH is done as an arithmetic right shift.

Top module: `boxcar_lpf`

## Requirements
- R1: While reset is active, and on the first clock after reset is released, `avg_out` is 0 and `avg_vld` is 0.
- R2: After an accepted sample, `avg_out` equals floor(S / 2^DEPTH). S is the sum of the last 2^DEPTH accepted samples, each read as a signed two's-complement value. Rounding is toward negative infinity.
- R3: Until 2^DEPTH samples have been accepted since reset, the history slots that have not yet been filled count as zero in S.
- R4: `avg_vld` is 1 exactly in the clock cycle that follows a cycle with `smp_en` = 1. The new `avg_out` is visible in that same cycle.
- R5: A cycle with `smp_en` = 0 has no effect. `avg_vld` stays 0, `avg_out` keeps its value, and `smp_in` is not taken into the history.
- R6: A run of 2^DEPTH full-scale samples produces exactly that value at the output, with no wrap-around. This holds for both the most negative and the most positive value.
- R7: The window length is 2^DEPTH, set by the DEPTH parameter. The sample width is set by WIDTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Strobe that accepts `smp_in` as a new sample |
| smp_in | input | WIDTH | Signed input sample |
| avg_out | output | WIDTH | Signed averaged sample |
| avg_vld | output | 1 | Single-cycle flag that marks a new `avg_out` |

## Verification
A corrupted history slot or a wrong running sum would not stay hidden. When the faulty slot leaves the window, or when the sum drifts, the output moves away from the true mean. That shows on `avg_out` in the cycle after the next accepted sample, and it persists for at least 2^DEPTH accepted samples. A drifted sum never heals by itself, so an error in it lasts indefinitely.

Full-scale runs expose any narrowing of the sum width. Long ramps cover every slot of the history. Idle strobe gaps catch a history that advances when `smp_en` is low.

// File: rtl/boxcar_lpf.sv
module boxcar_lpf #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_en,
  input  logic signed [WIDTH-1:0] smp_in,
  output logic signed [WIDTH-1:0] avg_out,
  output logic                    avg_vld
);
  localparam int TAPS = 1 << DEPTH;
  localparam int SW   = WIDTH + DEPTH;

  logic signed [WIDTH-1:0] hist [TAPS];
  logic [DEPTH-1:0]        wr_ptr;
  logic signed [SW-1:0]    acc;
  logic signed [SW-1:0]    acc_nx;
  logic signed [WIDTH-1:0] leaving;

  assign leaving = hist[wr_ptr];
  assign acc_nx  = acc + SW'(smp_in) - SW'(leaving);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) hist[i] <= '0;
      wr_ptr  <= '0;
      acc     <= '0;
      avg_out <= '0;
      avg_vld <= 1'b0;
    end else begin
      avg_vld <= smp_en;
      if (smp_en) begin
        hist[wr_ptr] <= smp_in;
        wr_ptr       <= wr_ptr + 1'b1;
        acc          <= acc_nx;
        avg_out      <= acc_nx[SW-1:DEPTH];
      end
    end
  end
endmodule

// File: rtl/boxcar_lpf_chk.sv
module boxcar_lpf_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_en,
  input logic [WIDTH-1:0] avg_out,
  input logic             avg_vld
);
  // R1
  out_after_reset_chk: assert property (@(posedge clk) $rose(rst_n) |-> (avg_out == '0 && !avg_vld));
  // R4
  vld_follows_en_chk: assert property (@(posedge clk) disable iff (!rst_n) smp_en |=> avg_vld);
  // R5
  no_vld_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !smp_en |=> !avg_vld);
  // R5
  out_holds_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(avg_out) |-> avg_vld);
endmodule

bind boxcar_lpf boxcar_lpf_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .avg_out(avg_out), .avg_vld(avg_vld)
);

// File: tb/boxcar_lpf_tb.sv
module boxcar_lpf_tb;
  localparam int W = 8;
  localparam int D = 3;
  localparam int N = 1 << D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic signed [W-1:0] din = '0;
  logic signed [W-1:0] dout;
  logic vld;

  int nvec = 0;
  int nbad = 0;
  int mhist [N];
  int mptr = 0;
  int last_out = 0;

  always #2 clk = ~clk;

  boxcar_lpf #(.WIDTH(W), .DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_en(en), .smp_in(din), .avg_out(dout), .avg_vld(vld)
  );

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int v, input bit e, input string req);
    int s;
    @(negedge clk);
    din = W'(v);
    en  = e;
    if (e) begin
      mhist[mptr] = v;
      mptr = (mptr + 1) % N;
    end
    @(negedge clk);
    en = 1'b0;
    s = 0;
    for (int i = 0; i < N; i++) s += mhist[i];
    if (e) last_out = s >>> D;
    chk({req, " R4 vld"}, int'(vld), int'(e));
    chk({req, " out"}, int'(dout), last_out);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 out in reset", int'(dout), 0);
    chk("R1 vld in reset", int'(vld), 0);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) mhist[i] = 0;
    mptr = 0;
    last_out = 0;
  endtask

  initial begin
    #400000;
    nbad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    do_reset();
    // R3: partial fill counts empty slots as zero
    for (int i = 0; i < N; i++) step(100, 1'b1, "R3 fill");
    // R2 square wave with quarter-rate strobe, R5 idle gaps ignore input
    for (int k = 0; k < 40; k++) begin
      step(((k / 4) % 2) ? 90 : -90, 1'b1, "R2 square");
      for (int g = 0; g < 3; g++) step(55 - g * 70, 1'b0, "R5 idle");
    end
    // R2 full ramp over every code, R7 window of 2^DEPTH
    for (int v = -128; v < 128; v++) step(v, 1'b1, "R2 R7 ramp");
    // R6 full-scale negative and positive
    for (int i = 0; i < N + 2; i++) step(-128, 1'b1, "R6 min");
    chk("R6 min settle", int'(dout), -128);
    for (int i = 0; i < N + 2; i++) step(127, 1'b1, "R6 max");
    chk("R6 max settle", int'(dout), 127);
    // R2 alternating small odd values exercise floor rounding
    for (int i = 0; i < 64; i++) step((i % 3 == 0) ? -1 : ((i % 2) ? 3 : -5), 1'b1, "R2 round");
    // R1 reset mid-stream clears history
    do_reset();
    step(64, 1'b1, "R1 R3 after reset");
    for (int i = 0; i < 3 * N; i++) step((i * 37) % 256 - 128, (i % 2) == 0, "R2 R5 mixed");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule